// File: doc/BRIEF.md
# Multiplexed LCD Backplane Phase Sequencer

This block produces the digital timing for the four backplane (common) drivers of a multiplexed LCD. A 2-bit mode input chooses static drive or 1:2, 1:3 or 1:4 multiplexing. Each pulse on the frame-tick input moves the sequencer to the next active row. After the last active row it returns to row 0 and the frame is complete.

For each backplane the block gives a select flag and a polarity bit. It also outputs the current row index, which the segment logic uses to fetch the matching row of display data. Backplanes left unused by a mode do not go idle. Each one copies an active backplane in a fixed pattern, so pins that carry the same signal can be wired together for extra drive.

The drive polarity flips once per completed frame, so the waveform averages to zero. A mode change is applied only at the end of a frame. Voltage levels, bias and the analog drivers are outside this block.

Top module: `lcd_bp_sequencer`

## Requirements
- R1: While reset is asserted, and until the first cycle after the synchronised release, every bit of `bp_sel_o` and `bp_pol_o` is 0 and `row_o` is 0.
- R2: `mode_i` is encoded as 00 = static (1 row), 01 = 1:2 (2 rows), 10 = 1:3 (3 rows), 11 = 1:4 (4 rows). Each frame tick adds one to `row_o`. From the last row of the mode in effect, a tick returns `row_o` to 0.
- R3: In 1:4 mode, backplane k is selected exactly when `row_o` equals k. Exactly one of the four is selected.
- R4: In 1:3 mode, backplanes 0, 1 and 2 are selected on rows 0, 1 and 2. Backplane 3 always carries the same select and polarity values as backplane 1.
- R5: In 1:2 mode, backplanes 0 and 2 carry identical values and are selected on row 0. Backplanes 1 and 3 carry identical values and are selected on row 1.
- R6: In static mode, all four backplanes are selected and carry identical values.
- R7: While running, the backplane whose number equals `row_o` is always selected. Row n of the display data is therefore paired with backplane n.
- R8: The frame polarity starts at 0 after reset. It inverts on each tick that completes a frame and on no other cycle.
- R9: A new `mode_i` value is taken up only on the tick that completes a frame. At that point `row_o` is 0. Changes of `mode_i` in the middle of a frame have no effect on the outputs.
- R10: In a cycle without a frame tick, all outputs keep their values.
- R11: While running, a selected backplane drives the frame polarity on `bp_pol_o`. An unselected backplane drives the inverse of the frame polarity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| frame_tick_i | input | 1 | One-cycle pulse that advances to the next row |
| mode_i | input | 2 | Requested multiplex mode (see R2) |
| bp_sel_o | output | 4 | Per-backplane select flag (bit k = backplane k) |
| bp_pol_o | output | 4 | Per-backplane polarity bit |
| row_o | output | 2 | Current row index for the segment data path |

## Verification
The case that is hardest to reach from the ports is a mode request that changes in the middle of a frame and must be held off until the frame wraps. This is hardest when the frame is about to end and the new mode has a different row count. The bench walks through every pair of old and new modes. It changes `mode_i` at every row position inside a frame, checks after each tick that the old duplication pattern and wrap point still apply, and then checks that the new mode starts at row 0 with the polarity inverted. Idle cycles without a tick are mixed in to show that the outputs hold.

// File: rtl/lcd_bp_pkg.sv
package lcd_bp_pkg;
  localparam int NUM_BP = 4;
  localparam int ROW_W  = $clog2(NUM_BP);

  typedef enum logic [1:0] {
    MUX_STATIC = 2'b00,
    MUX_2      = 2'b01,
    MUX_3      = 2'b10,
    MUX_4      = 2'b11
  } mux_mode_e;

  // index of the last active row in a mode
  function automatic logic [ROW_W-1:0] last_row(input mux_mode_e m);
    return ROW_W'(m);
  endfunction

  // row that a given backplane follows in a mode
  function automatic logic [ROW_W-1:0] bp_row(input mux_mode_e m, input int k);
    logic [ROW_W-1:0] r;
    case (m)
      MUX_STATIC: r = '0;
      MUX_2:      r = ROW_W'(k % 2);
      MUX_3:      r = (k == 3) ? ROW_W'(1) : ROW_W'(k);
      default:    r = ROW_W'(k);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/lcd_rst_sync.sv
module lcd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/lcd_frame_ctrl.sv
module lcd_frame_ctrl
  import lcd_bp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  mux_mode_e        mode_req_i,
  output mux_mode_e        mode_q_o,
  output logic [ROW_W-1:0] row_q_o,
  output logic             pol_q_o,
  output logic             run_q_o
);
  mux_mode_e        mode_q, mode_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             pol_q, pol_d;
  logic             run_q, run_d;
  logic             frame_end;
  logic             en;

  assign frame_end = (row_q == last_row(mode_q));
  assign en        = tick_i | ~run_q;

  always_comb begin
    mode_d = mode_q;
    row_d  = row_q;
    pol_d  = pol_q;
    run_d  = 1'b1;
    if (!run_q) begin
      mode_d = mode_req_i;
      row_d  = '0;
    end else if (frame_end) begin
      mode_d = mode_req_i;
      row_d  = '0;
      pol_d  = ~pol_q;
    end else begin
      row_d  = row_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MUX_STATIC;
      row_q  <= '0;
      pol_q  <= 1'b0;
      run_q  <= 1'b0;
    end else if (en) begin
      mode_q <= mode_d;
      row_q  <= row_d;
      pol_q  <= pol_d;
      run_q  <= run_d;
    end
  end

  assign mode_q_o = mode_q;
  assign row_q_o  = row_q;
  assign pol_q_o  = pol_q;
  assign run_q_o  = run_q;
endmodule

// File: rtl/lcd_bp_map.sv
module lcd_bp_map
  import lcd_bp_pkg::*;
(
  input  mux_mode_e         mode_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic              pol_i,
  input  logic              run_i,
  output logic [NUM_BP-1:0] sel_o,
  output logic [NUM_BP-1:0] pol_o
);
  for (genvar k = 0; k < NUM_BP; k++) begin : g_bp
    logic [ROW_W-1:0] follow;
    always_comb begin
      follow   = bp_row(mode_i, k);
      sel_o[k] = run_i && (follow == row_i);
      pol_o[k] = run_i && (sel_o[k] ? pol_i : ~pol_i);
    end
  end
endmodule

// File: rtl/lcd_bp_sequencer.sv
module lcd_bp_sequencer
  import lcd_bp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_tick_i,
  input  logic [1:0]              mode_i,
  output logic [lcd_bp_pkg::NUM_BP-1:0] bp_sel_o,
  output logic [lcd_bp_pkg::NUM_BP-1:0] bp_pol_o,
  output logic [lcd_bp_pkg::ROW_W-1:0]  row_o
);
  logic             rst_sync_n;
  mux_mode_e        act_mode;
  logic [ROW_W-1:0] row_q;
  logic             pol_q;
  logic             run_q;

  lcd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lcd_frame_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tick_i     (frame_tick_i),
    .mode_req_i (mux_mode_e'(mode_i)),
    .mode_q_o   (act_mode),
    .row_q_o    (row_q),
    .pol_q_o    (pol_q),
    .run_q_o    (run_q)
  );

  lcd_bp_map u_map (
    .mode_i (act_mode),
    .row_i  (row_q),
    .pol_i  (pol_q),
    .run_i  (run_q),
    .sel_o  (bp_sel_o),
    .pol_o  (bp_pol_o)
  );

  assign row_o = row_q;
endmodule

// File: rtl/lcd_bp_sequencer_chk.sv
module lcd_bp_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_tick_i,
  input logic       run,
  input logic [1:0] act_mode,
  input logic [3:0] bp_sel_o,
  input logic [3:0] bp_pol_o,
  input logic [1:0] row_o
);
  AST_IDLE_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (bp_sel_o == 4'b0 && bp_pol_o == 4'b0 && row_o == 2'd0)); // R1
  AST_ROW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (row_o <= act_mode)); // R2
  AST_MUX4_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (run && act_mode == 2'b11) |-> $onehot(bp_sel_o)); // R3
  AST_MUX3_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (run && act_mode == 2'b10) |-> (bp_sel_o[3] == bp_sel_o[1] && bp_pol_o[3] == bp_pol_o[1])); // R4
  AST_MUX2_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && act_mode == 2'b01) |-> (bp_sel_o[3:2] == bp_sel_o[1:0] && bp_pol_o[3:2] == bp_pol_o[1:0])); // R5
  AST_STATIC_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (run && act_mode == 2'b00) |-> (bp_sel_o == 4'hF && $countones(bp_pol_o) inside {0, 4})); // R6
  AST_ROW_BP_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> bp_sel_o[row_o]); // R7
  AST_MODE_AT_ROW0: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !$stable(act_mode)) |-> (row_o == 2'd0)); // R9
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !frame_tick_i) |=> ($stable(bp_sel_o) && $stable(bp_pol_o) && $stable(row_o))); // R10
  AST_POL_OPPOSE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ($countones(bp_pol_o ^ bp_sel_o) inside {0, 4})); // R11
endmodule

bind lcd_bp_sequencer lcd_bp_sequencer_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_tick_i (frame_tick_i),
  .run          (run_q),
  .act_mode     (act_mode),
  .bp_sel_o     (bp_sel_o),
  .bp_pol_o     (bp_pol_o),
  .row_o        (row_o)
);

// File: tb/tb_lcd_bp_sequencer.sv
module tb_lcd_bp_sequencer;
  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       frame_tick_i;
  logic [1:0] mode_i;
  logic [3:0] bp_sel_o;
  logic [3:0] bp_pol_o;
  logic [1:0] row_o;

  int n_checks = 0;
  int n_fail   = 0;

  int m_mode;
  int m_row;
  int m_pol;

  lcd_bp_sequencer dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_tick_i (frame_tick_i),
    .mode_i       (mode_i),
    .bp_sel_o     (bp_sel_o),
    .bp_pol_o     (bp_pol_o),
    .row_o        (row_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int follow_row(input int mode, input int k);
    case (mode)
      0:       return 0;
      1:       return k % 2;
      2:       return (k == 3) ? 1 : k;
      default: return k;
    endcase
  endfunction

  function automatic string mode_tag(input int mode);
    case (mode)
      0:       return "R6 static";
      1:       return "R5 1:2";
      2:       return "R4 1:3";
      default: return "R3 1:4";
    endcase
  endfunction

  task automatic check_model(input string ctx);
    int esel = 0;
    int epol = 0;
    for (int k = 0; k < 4; k++) begin
      if (follow_row(m_mode, k) == m_row) begin
        esel |= (1 << k);
        if (m_pol != 0) epol |= (1 << k);
      end else if (m_pol == 0) begin
        epol |= (1 << k);
      end
    end
    chk({mode_tag(m_mode), " sel ", ctx}, int'(bp_sel_o), esel);
    chk({"R8 R11 pol ", ctx}, int'(bp_pol_o), epol);
    chk({"R2 R7 row ", ctx}, int'(row_o), m_row);
  endtask

  task automatic do_reset(input int mode);
    @(negedge clk);
    mode_i       = 2'(mode);
    frame_tick_i = 1'b0;
    rst_n        = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset sel", int'(bp_sel_o), 0);
    chk("R1 reset pol", int'(bp_pol_o), 0);
    chk("R1 reset row", int'(row_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 release sel", int'(bp_sel_o), 0);
    repeat (3) @(negedge clk);
    m_mode = mode;
    m_row  = 0;
    m_pol  = 0;
    check_model("after reset");
  endtask

  task automatic tick(input string ctx);
    frame_tick_i = 1'b1;
    @(negedge clk);
    frame_tick_i = 1'b0;
    if (m_row == m_mode) begin
      m_row  = 0;
      m_pol  = 1 - m_pol;
      m_mode = int'(mode_i);
    end else begin
      m_row++;
    end
    check_model(ctx);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    rst_n        = 1'b0;
    frame_tick_i = 1'b0;
    mode_i       = 2'b00;
    for (int m = 0; m < 4; m++) begin
      do_reset(m);
      // several full frames in a fixed mode
      for (int t = 0; t < 3 * (m + 1) + 1; t++) tick("steady");
      // idle cycles hold everything
      repeat (3) @(negedge clk);
      check_model("R10 idle hold");
    end
    // mode change at every position within a frame, every pair of modes
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        for (int p = 0; p <= a; p++) begin
          do_reset(a);
          for (int t = 0; t < p; t++) tick("pre");
          mode_i = 2'(b);
          @(negedge clk);
          check_model("R9 req mid-frame no effect");
          for (int t = p; t < a; t++) tick("R9 old mode kept");
          tick("R9 new mode at wrap");
          chk("R9 mode taken row", int'(row_o), 0);
          for (int t = 0; t < b + 2; t++) tick("R9 new mode run");
        end
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule